// File: doc/BRIEF.md
# Dual Reference Rate Classifier

This block sits at the front of a timing loop. It has two reference clock inputs that run at the same time and can come from unrelated sources. Both are sampled by a fast local clock. For each input, the block counts the cycles between rising edges. It then decides which of four supported reference rates the input carries: 8 kHz, 1.544 MHz, 2.048 MHz or 19.44 MHz. A period that falls in none of the four windows marks that input as unusable.

Each recognised input yields a one-cycle strobe on its active edge. The active edge depends on the rate found. The three slow rates strobe on the falling edge and the 19.44 MHz rate strobes on the rising edge. A select pin chooses one input. The block then passes the strobe and rate code of that input to the phase detector that follows it.

Every window is a parameter given in sampling-clock cycles. The default values are scaled down so that the block can be exercised quickly.

Top module: `dual_ref_classifier`

## Requirements
- R1: The rate code is 2'b00 for 8 kHz (period RATE0_MIN..RATE0_MAX), 2'b01 for 1.544 MHz (RATE1 window), 2'b10 for 2.048 MHz (RATE2 window) and 2'b11 for 19.44 MHz (RATE3 window). With the default values the windows are 60..80, 15..19, 10..13 and 4..6 cycles. `sel_rate` shows the code of the selected input.
- R2: An input's ok flag rises only after three consecutive measured periods fall in the same window. The flag is set in the cycle after the internal rising-edge event that ends the third period. After two periods it is still low.
- R3: A single period outside every window, or one in a different window, clears the ok flag.
- R4: If no rising edge arrives for more than TIMEOUT cycles (default 96, which must exceed RATE0_MAX), the ok flag clears.
- R5: For codes 00, 01 and 10 the strobe follows the falling edge of the input. `sel_stb` is high for exactly one cycle, in the third sampling cycle after the pin changes, which allows for two synchronizer stages and one output register.
- R6: For code 11 the strobe follows the rising edge, with the same three-cycle latency.
- R7: `ref_sel` = 0 selects the primary input and `ref_sel` = 1 selects the secondary input. Both inputs are classified independently and at the same time.
- R8: After `ref_sel` changes, `sel_stb` stays low until an active edge of the newly chosen input. The first strobe after the change lines up with that input's edge.
- R9: A selected input whose ok flag is low never produces a strobe. After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_ref | input | 1 | Primary reference clock, asynchronous |
| sec_ref | input | 1 | Secondary reference clock, asynchronous |
| ref_sel | input | 1 | 0 selects primary, 1 selects secondary |
| sel_stb | output | 1 | One-cycle strobe on the selected input's active edge |
| sel_rate | output | 2 | Rate code of the selected input |
| pri_ok | output | 1 | Primary input recognised |
| sec_ok | output | 1 | Secondary input recognised |

## Verification
Internal state that goes wrong shows up at the ports within one reference period. If the streak counter is corrupted, the ok flag rises one period early or late, and the bench checks this in the exact gap between the third and fourth edges. If the stored rate code is wrong, the strobe moves to the other edge. The bench measures the latency of every strobe from the last edge it drove, so a moved strobe shows up as a distance other than three cycles. If a selection switch leaks, a strobe appears that is aligned to the old input's edges.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
   typedef enum logic [1:0] {
      RATE_8K   = 2'b00,
      RATE_1M5  = 2'b01,
      RATE_2M0  = 2'b10,
      RATE_19M4 = 2'b11
   } rate_e;

   localparam int unsigned NUM_RATES  = 4;
   localparam int unsigned NUM_INPUTS = 2;
endpackage

// File: rtl/refclk_edge_sync.sv
module refclk_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("refclk_edge_sync: STAGES must be at least 2");
   end

   // STAGES synchronizer flops plus one history flop
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign rise =  chain[STAGES-1] & ~chain[STAGES];
   assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/refclk_period_class.sv
module refclk_period_class
   import refclk_pkg::*;
#(
   parameter int unsigned RATE0_MIN = 60,
   parameter int unsigned RATE0_MAX = 80,
   parameter int unsigned RATE1_MIN = 15,
   parameter int unsigned RATE1_MAX = 19,
   parameter int unsigned RATE2_MIN = 10,
   parameter int unsigned RATE2_MAX = 13,
   parameter int unsigned RATE3_MIN = 4,
   parameter int unsigned RATE3_MAX = 6,
   parameter int unsigned TIMEOUT   = 96,
   parameter int unsigned STREAK    = 3
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  rise,
   input  logic  fall,
   output logic  ok,
   output rate_e rate,
   output logic  stb
);
   localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
   localparam int unsigned STK_W = $clog2(STREAK + 1);
   localparam int unsigned LO [NUM_RATES] = '{RATE0_MIN, RATE1_MIN, RATE2_MIN, RATE3_MIN};
   localparam int unsigned HI [NUM_RATES] = '{RATE0_MAX, RATE1_MAX, RATE2_MAX, RATE3_MAX};

   logic [CNT_W-1:0] cnt;
   logic [STK_W-1:0] streak;
   logic             seen;
   logic             hit;
   rate_e            hit_rate;
   rate_e            cand;

   // window match on the running count, used when a rising edge closes a period
   always_comb begin
      hit      = 1'b0;
      hit_rate = RATE_8K;
      for (int i = 0; i < int'(NUM_RATES); i++) begin
         if (32'(cnt) >= LO[i] && 32'(cnt) <= HI[i]) begin
            hit      = 1'b1;
            hit_rate = rate_e'(i[1:0]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         streak <= '0;
         seen   <= 1'b0;
         cand   <= RATE_8K;
         ok     <= 1'b0;
      end else if (rise) begin
         cnt  <= CNT_W'(1);
         seen <= 1'b1;
         if (seen) begin
            if (hit && hit_rate == cand && streak != '0) begin
               if (32'(streak) < STREAK) streak <= streak + 1'b1;
               if (32'(streak) >= STREAK - 1) ok <= 1'b1;
            end else if (hit) begin
               cand   <= hit_rate;
               streak <= STK_W'(1);
               ok     <= 1'b0;
            end else begin
               streak <= '0;
               ok     <= 1'b0;
            end
         end
      end else if (32'(cnt) >= TIMEOUT) begin
         seen   <= 1'b0;
         streak <= '0;
         ok     <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign rate = cand;
   assign stb  = ok & ((cand == RATE_19M4) ? rise : fall);
endmodule

// File: rtl/refclk_select.sv
module refclk_select
   import refclk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_pin,
   input  logic [1:0] stb_in,
   input  rate_e      rate0,
   input  rate_e      rate1,
   output logic       out_stb,
   output rate_e      out_rate,
   output logic       sel_now
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_now  <= 1'b0;
         out_stb  <= 1'b0;
         out_rate <= RATE_8K;
      end else begin
         sel_now  <= sel_pin;
         out_rate <= sel_pin ? rate1 : rate0;
         // a change blanks the strobe; the next one comes from an edge of the new input
         out_stb  <= (sel_pin == sel_now) & stb_in[sel_now];
      end
   end
endmodule

// File: rtl/dual_ref_classifier.sv
module dual_ref_classifier
   import refclk_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RATE0_MIN   = 60,
   parameter int unsigned RATE0_MAX   = 80,
   parameter int unsigned RATE1_MIN   = 15,
   parameter int unsigned RATE1_MAX   = 19,
   parameter int unsigned RATE2_MIN   = 10,
   parameter int unsigned RATE2_MAX   = 13,
   parameter int unsigned RATE3_MIN   = 4,
   parameter int unsigned RATE3_MAX   = 6,
   parameter int unsigned TIMEOUT     = 96,
   parameter int unsigned STREAK      = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pri_ref,
   input  logic       sec_ref,
   input  logic       ref_sel,
   output logic       sel_stb,
   output logic [1:0] sel_rate,
   output logic       pri_ok,
   output logic       sec_ok
);
   if (!(RATE3_MIN >= 4 && RATE3_MIN <= RATE3_MAX && RATE3_MAX < RATE2_MIN &&
         RATE2_MIN <= RATE2_MAX && RATE2_MAX < RATE1_MIN &&
         RATE1_MIN <= RATE1_MAX && RATE1_MAX < RATE0_MIN &&
         RATE0_MIN <= RATE0_MAX && RATE0_MAX < TIMEOUT)) begin : g_bad_windows
      $error("dual_ref_classifier: windows must be ordered, disjoint and below TIMEOUT");
   end
   if (STREAK < 1) begin : g_bad_streak
      $error("dual_ref_classifier: STREAK must be at least 1");
   end

   logic [NUM_INPUTS-1:0] ref_v;
   logic [NUM_INPUTS-1:0] rise_v;
   logic [NUM_INPUTS-1:0] fall_v;
   logic [NUM_INPUTS-1:0] ok_v;
   logic [NUM_INPUTS-1:0] stb_v;
   rate_e                 rate_v [NUM_INPUTS];
   rate_e                 out_rate;
   logic                  sel_now;

   assign ref_v = {sec_ref, pri_ref};

   for (genvar g = 0; g < int'(NUM_INPUTS); g++) begin : g_in
      refclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (ref_v[g]),
         .rise (rise_v[g]),
         .fall (fall_v[g])
      );
      refclk_period_class #(
         .RATE0_MIN(RATE0_MIN), .RATE0_MAX(RATE0_MAX),
         .RATE1_MIN(RATE1_MIN), .RATE1_MAX(RATE1_MAX),
         .RATE2_MIN(RATE2_MIN), .RATE2_MAX(RATE2_MAX),
         .RATE3_MIN(RATE3_MIN), .RATE3_MAX(RATE3_MAX),
         .TIMEOUT(TIMEOUT), .STREAK(STREAK)
      ) u_class (
         .clk  (clk),
         .rst_n(rst_n),
         .rise (rise_v[g]),
         .fall (fall_v[g]),
         .ok   (ok_v[g]),
         .rate (rate_v[g]),
         .stb  (stb_v[g])
      );
   end

   refclk_select u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_pin (ref_sel),
      .stb_in  (stb_v),
      .rate0   (rate_v[0]),
      .rate1   (rate_v[1]),
      .out_stb (sel_stb),
      .out_rate(out_rate),
      .sel_now (sel_now)
   );

   assign sel_rate = out_rate;
   assign pri_ok   = ok_v[0];
   assign sec_ok   = ok_v[1];
endmodule

// File: rtl/dual_ref_classifier_chk.sv
module dual_ref_classifier_chk #(
   parameter int unsigned TIMEOUT = 96
) (
   input logic clk,
   input logic rst_n,
   input logic sel_stb,
   input logic pri_ok,
   input logic sec_ok,
   input logic sel_now,
   input logic pri_rise
);
   logic [31:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                gap <= '0;
      else if (pri_rise)         gap <= '0;
      else if (gap != '1)        gap <= gap + 1'b1;
   end

   assert_ok_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pri_ok) |-> $past(pri_rise));

   assert_timeout_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (gap > TIMEOUT + 2) |-> !pri_ok);

   assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sel_stb |=> !sel_stb);

   assert_switch_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_now != $past(sel_now)) |-> !sel_stb);

   assert_stb_needs_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sel_stb |-> ($past(sel_now) ? $past(sec_ok) : $past(pri_ok)));
endmodule

bind dual_ref_classifier dual_ref_classifier_chk #(.TIMEOUT(TIMEOUT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel_stb (sel_stb),
   .pri_ok  (pri_ok),
   .sec_ok  (sec_ok),
   .sel_now (sel_now),
   .pri_rise(rise_v[0])
);

// File: tb/dual_ref_classifier_bench.sv
module dual_ref_classifier_bench;
   localparam int CLK_PERIOD = 10;
   localparam int TIMEOUT    = 96;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pri_ref, sec_ref, ref_sel;
   logic       sel_stb;
   logic [1:0] sel_rate;
   logic       pri_ok, sec_ok;

   dual_ref_classifier u_dual_ref_classifier (
      .clk(clk), .rst_n(rst_n), .pri_ref(pri_ref), .sec_ref(sec_ref),
      .ref_sel(ref_sel), .sel_stb(sel_stb), .sel_rate(sel_rate),
      .pri_ok(pri_ok), .sec_ok(sec_ok)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // waveform generators, driven at the falling clock edge
   int en   [2] = '{0, 0};
   int per  [2] = '{5, 5};
   int hi   [2] = '{2, 2};
   int ph   [2] = '{0, 0};
   int lvl  [2] = '{0, 0};
   int last_rise [2] = '{0, 0};
   int last_fall [2] = '{0, 0};
   int cyc = 0;
   int stb_cnt = 0;
   int d_rise = 0;
   int d_fall = 0;
   int first_rise = -1;
   int first_fall = -1;

   initial begin
      pri_ref = 1'b0;
      sec_ref = 1'b0;
      ref_sel = 1'b0;
   end

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (sel_stb) begin
         d_rise = cyc - last_rise[ref_sel];
         d_fall = cyc - last_fall[ref_sel];
         if (stb_cnt == 0) begin
            first_rise = d_rise;
            first_fall = d_fall;
         end
         stb_cnt = stb_cnt + 1;
      end
      for (int i = 0; i < 2; i++) begin
         int nl;
         if (en[i] != 0) ph[i] = (ph[i] + 1 >= per[i]) ? 0 : ph[i] + 1;
         nl = (en[i] != 0 && ph[i] < hi[i]) ? 1 : 0;
         if (nl == 1 && lvl[i] == 0) last_rise[i] = cyc;
         if (nl == 0 && lvl[i] == 1) last_fall[i] = cyc;
         lvl[i] = nl;
      end
      pri_ref = lvl[0][0];
      sec_ref = lvl[1][0];
   end

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // start input i from phase so that its first rise is on the next negedge
   task automatic start_in(input int i, input int p, input int h);
      @(posedge clk);
      per[i] = p;
      hi[i]  = h;
      ph[i]  = p - 1;
      en[i]  = 1;
   endtask

   task automatic stop_in(input int i);
      @(posedge clk);
      en[i] = 0;
   endtask

   task automatic t_reset();
      chk(sel_stb == 1'b0, "R9 reset stb", int'(sel_stb), 0);
      chk(pri_ok == 1'b0 && sec_ok == 1'b0, "R9 reset ok", int'({pri_ok, sec_ok}), 0);
      chk(sel_rate == 2'b00, "R9 reset rate", int'(sel_rate), 0);
   endtask

   task automatic t_rate(input int p, input int h, input int code);
      int e;
      stop_in(0);
      wait_cyc(TIMEOUT + 10);
      ref_sel = 1'b0;
      start_in(0, p, h);
      @(negedge clk);
      e = cyc;                         // first rise driven here
      while (cyc < e + 3*p - 1) @(negedge clk);
      chk(pri_ok == 1'b0, "R2 not ok after two periods", int'(pri_ok), 0);
      while (cyc < e + 3*p + 4) @(negedge clk);
      chk(pri_ok == 1'b1, "R2 ok after three periods", int'(pri_ok), 1);
      wait_cyc(4);
      chk(sel_rate == code[1:0], "R1 rate code", int'(sel_rate), code);
      stb_cnt = 0;
      wait_cyc(4*p);
      chk(stb_cnt == 4, "R5 one strobe per period", stb_cnt, 4);
      if (code == 3) chk(d_rise == 3, "R6 rising edge strobe latency", d_rise, 3);
      else           chk(d_fall == 3, "R5 falling edge strobe latency", d_fall, 3);
   endtask

   task automatic t_bad_period();
      // pri runs at code 01 here; stretch exactly one period
      wait_cyc(1);
      while (last_rise[0] != cyc) @(negedge clk);
      per[0] = 30;
      wait_cyc(33);
      chk(pri_ok == 1'b0, "R3 out-of-window period clears", int'(pri_ok), 0);
      per[0] = 17;
      wait_cyc(6*17);
      chk(pri_ok == 1'b1, "R3 recovers after three good periods", int'(pri_ok), 1);
      per[0] = 12;  hi[0] = 5;   // one period of another window
      wait_cyc(15);
      chk(pri_ok == 1'b0, "R3 period in other window clears", int'(pri_ok), 0);
   endtask

   task automatic t_timeout();
      stop_in(0);
      wait_cyc(TIMEOUT - 20);
      chk(pri_ok == 1'b1, "R4 ok holds inside timeout", int'(pri_ok), 1);
      wait_cyc(40);
      chk(pri_ok == 1'b0, "R4 missing edge clears", int'(pri_ok), 0);
      stb_cnt = 0;
      wait_cyc(100);
      chk(stb_cnt == 0, "R9 no strobe from invalid input", stb_cnt, 0);
   endtask

   task automatic t_dual_switch();
      start_in(0, 17, 8);
      start_in(1, 5, 2);
      wait_cyc(8*17);
      chk(pri_ok && sec_ok, "R7 both inputs ok together", int'({pri_ok, sec_ok}), 3);
      chk(sel_rate == 2'b01, "R7 primary selected", int'(sel_rate), 1);
      @(posedge clk); #1;
      ref_sel = 1'b1;
      stb_cnt = 0;
      wait_cyc(3);
      chk(sel_rate == 2'b11, "R7 secondary selected", int'(sel_rate), 3);
      wait_cyc(20);
      chk(first_rise == 3, "R8 first strobe aligned to new input", first_rise, 3);
      @(posedge clk); #1;
      ref_sel = 1'b0;
      stb_cnt = 0;
      wait_cyc(40);
      chk(first_fall == 3, "R8 first strobe after return aligned", first_fall, 3);
      chk(stb_cnt == 2 || stb_cnt == 3, "R7 primary strobe rate", stb_cnt, 2);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      wait_cyc(3);
      t_reset();
      @(posedge clk); #1;
      rst_n = 1'b1;
      wait_cyc(2);
      t_rate(70, 30, 0);
      t_rate(5, 2, 3);
      t_rate(12, 5, 2);
      t_rate(17, 8, 1);
      t_bad_period();
      per[0] = 17; hi[0] = 8;
      wait_cyc(6*17);
      t_timeout();
      t_dual_switch();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule